// File: doc/BRIEF.md
# Dynamic Local Bus Width Adapter

This block sits between the target side of a 32-bit host interface and a narrow peripheral bus. It turns each 32-bit access into local cycles. The target side supplies a dword address, four active-low byte enables, write data and a direction flag, and starts the access with a one-cycle strobe. The local bus can be 32, 16 or 8 bits wide. In 32-bit mode the access is one local cycle. On a narrower bus the block issues one local cycle per enabled half or per enabled byte. On reads it assembles the returned data into a 32-bit word.

A narrow local device has no use for all four lane enables. The adapter therefore drives the low byte-address bits on some of those lines, so that byte addressing stays linear on every width. A wait input from the device stretches the current local cycle. The target side sees this only as a later completion.

Top module: `lbw_adapter`

## Requirements
- R1: `bus_mode` encodes 0 as 32-bit, 1 as 16-bit and 2 as 8-bit. Code 3 behaves as 32-bit. In 32-bit mode an access with at least one enable is exactly one local cycle. During that cycle `loc_lbe_n` equals the latched `tgt_be_n`, and byte i of the write data travels on `loc_wdata[8i+7:8i]`.
- R2: In 16-bit mode the halves are bytes 0-1 and bytes 2-3. Each half that has any byte enabled becomes one local cycle, lower half first. A half with no byte enabled is skipped. During such a cycle, `loc_lbe_n[1]` is the half index (address bit 1), `loc_lbe_n[0]` is the active-low enable of the lower byte of that half, `loc_lbe_n[3]` is the active-low enable of the upper byte, and `loc_lbe_n[2]` is 1. The data moves on `loc_wdata[15:0]` and `loc_rdata[15:0]`.
- R3: In 8-bit mode each enabled byte becomes one local cycle, in ascending byte order, and disabled bytes are skipped. During such a cycle `loc_lbe_n[1:0]` is the byte index, `loc_lbe_n[3:2]` is 2'b11, and the data moves on bit 7 to bit 0 of the local data.
- R4: In the read result, each enabled byte is taken from the local lane that carried it. Bytes that are not enabled read as zero. The result is presented on `tgt_rdata` in the cycle `tgt_done` is high.
- R5: A local cycle completes on the first clock edge at which `loc_strobe` is high and `loc_wait` is low. While `loc_wait` is high, `loc_strobe`, `loc_lbe_n` and `loc_wdata` hold their values.
- R6: `tgt_done` is high for exactly one cycle, the cycle after the last local cycle completes. If no byte is enabled, no local cycle is issued and `tgt_done` is high in the cycle after the start is accepted.
- R7: A start is accepted only when `tgt_busy` is low. `tgt_busy` is high from the cycle after acceptance through the `tgt_done` cycle. A start while busy has no effect, and no local cycle occurs while idle.
- R8: The width, address, enables, direction and write data are captured when the start is accepted. Later changes on those inputs do not affect the running access.
- R9: After reset, `tgt_busy`, `tgt_done` and `loc_strobe` are low and `tgt_rdata` is zero.
- R10: While `loc_strobe` is high, `loc_wa` equals the captured dword address. Local data lanes that carry no enabled byte drive zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Local bus width code |
| tgt_start | input | 1 | Access start strobe |
| tgt_write | input | 1 | 1 = write, 0 = read |
| tgt_addr | input | ADDR_W | Dword address |
| tgt_be_n | input | 4 | Active-low byte enables |
| tgt_wdata | input | 32 | Write data |
| tgt_rdata | output | 32 | Assembled read data |
| tgt_done | output | 1 | One-cycle completion pulse |
| tgt_busy | output | 1 | Access in progress |
| loc_wa | output | ADDR_W | Local word address |
| loc_lbe_n | output | 4 | Lane enables / low address bits |
| loc_wdata | output | 32 | Local write data |
| loc_rdata | input | 32 | Local read data |
| loc_strobe | output | 1 | Local cycle active |
| loc_write | output | 1 | Local cycle direction |
| loc_wait | input | 1 | Local device wait request |

## Verification
A corrupted pending-byte mask shows up at once on `loc_lbe_n`: the cycle count is wrong or the address bits are out of order. A corrupted mask also moves `tgt_done` earlier or later. Wrong lane steering appears in the returned word at the done cycle, or on `loc_wdata` during the faulty local cycle. Each local cycle is compared in the clock it is driven, so a fault is reported within one cycle of its appearance.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int IDX_W  = $clog2(LANES);
    localparam int BUS_W  = LANES * LANE_W;

    typedef enum logic [1:0] {
        MODE_W32 = 2'd0,
        MODE_W16 = 2'd1,
        MODE_W8  = 2'd2,
        MODE_RSV = 2'd3
    } width_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Local data lane that carries host byte b in a given width mode.
    function automatic int unsigned lane_of(width_mode_e m, int unsigned b);
        case (m)
            MODE_W16: return b % 2;
            MODE_W8:  return 0;
            default:  return b;
        endcase
    endfunction
endpackage

// File: rtl/lbw_unit_sel.sv
module lbw_unit_sel
    import lbw_pkg::*;
(
    input  width_mode_e       mode,
    input  logic [LANES-1:0]  pend,
    output logic [LANES-1:0]  unit_mask,
    output logic [IDX_W-1:0]  first_idx
);
    logic [LANES-1:0] half_mask;

    always_comb begin
        first_idx = '0;
        // Descending scan leaves the lowest pending byte index.
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) first_idx = IDX_W'(i);
        end
        half_mask = {{(LANES/2){first_idx[IDX_W-1]}}, {(LANES/2){~first_idx[IDX_W-1]}}};
        case (mode)
            MODE_W16: unit_mask = pend & half_mask;
            MODE_W8:  unit_mask = (pend == '0) ? '0 : (LANES'(1) << first_idx);
            default:  unit_mask = pend;
        endcase
    end
endmodule

// File: rtl/lbw_lane_map.sv
module lbw_lane_map
    import lbw_pkg::*;
(
    input  width_mode_e       mode,
    input  logic [LANES-1:0]  unit_mask,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  loc_rdata,
    output logic [LANES-1:0]  lbe_n,
    output logic [BUS_W-1:0]  lane_wdata,
    output logic [BUS_W-1:0]  steer_rdata
);
    logic hi_half;
    assign hi_half = first_idx[IDX_W-1];

    // Read steering: each byte of the unit pulls from its local lane.
    for (genvar g = 0; g < LANES; g++) begin : g_steer
        assign steer_rdata[g*LANE_W +: LANE_W] =
            unit_mask[g] ? loc_rdata[lane_of(mode, g)*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        lane_wdata = '0;
        for (int i = 0; i < LANES; i++) begin
            if (unit_mask[i]) begin
                lane_wdata[lane_of(mode, i)*LANE_W +: LANE_W] =
                    lane_wdata[lane_of(mode, i)*LANE_W +: LANE_W] | wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        case (mode)
            MODE_W16: lbe_n = {~(hi_half ? unit_mask[3] : unit_mask[1]),
                               1'b1,
                               hi_half,
                               ~(hi_half ? unit_mask[2] : unit_mask[0])};
            MODE_W8:  lbe_n = {2'b11, first_idx};
            default:  lbe_n = ~unit_mask;
        endcase
    end
endmodule

// File: rtl/lbw_adapter.sv
module lbw_adapter
    import lbw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic              tgt_start,
    input  logic              tgt_write,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [3:0]        tgt_be_n,
    input  logic [31:0]       tgt_wdata,
    output logic [31:0]       tgt_rdata,
    output logic              tgt_done,
    output logic              tgt_busy,
    output logic [ADDR_W-1:0] loc_wa,
    output logic [3:0]        loc_lbe_n,
    output logic [31:0]       loc_wdata,
    input  logic [31:0]       loc_rdata,
    output logic              loc_strobe,
    output logic              loc_write,
    input  logic              loc_wait
);
    typedef struct packed {
        seq_state_e        state;
        width_mode_e       mode;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
        logic [LANES-1:0]  pend;
        logic [BUS_W-1:0]  rdata;
    } regs_t;

    regs_t q, d;

    logic [LANES-1:0] unit_mask;
    logic [IDX_W-1:0] first_idx;
    logic [BUS_W-1:0] steer_rdata;
    logic [LANES-1:0] remain;

    lbw_unit_sel u_sel (
        .mode      (q.mode),
        .pend      (q.pend),
        .unit_mask (unit_mask),
        .first_idx (first_idx)
    );

    lbw_lane_map u_map (
        .mode        (q.mode),
        .unit_mask   (unit_mask),
        .first_idx   (first_idx),
        .wdata       (q.wdata),
        .loc_rdata   (loc_rdata),
        .lbe_n       (loc_lbe_n),
        .lane_wdata  (loc_wdata),
        .steer_rdata (steer_rdata)
    );

    assign remain = q.pend & ~unit_mask;

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (tgt_start) begin
                    d.mode  = width_mode_e'(bus_mode);
                    d.write = tgt_write;
                    d.addr  = tgt_addr;
                    d.wdata = tgt_wdata;
                    d.pend  = ~tgt_be_n;
                    d.rdata = '0;
                    d.state = (tgt_be_n == '1) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!loc_wait) begin
                    d.rdata = q.rdata | steer_rdata;
                    d.pend  = remain;
                    if (remain == '0) d.state = ST_DONE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tgt_rdata  = q.rdata;
    assign tgt_done   = (q.state == ST_DONE);
    assign tgt_busy   = (q.state != ST_IDLE);
    assign loc_strobe = (q.state == ST_RUN);
    assign loc_write  = loc_strobe && q.write;
    assign loc_wa     = q.addr;
endmodule

// File: rtl/lbw_adapter_chk.sv
module lbw_adapter_chk
    import lbw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_mode,
    input logic              tgt_start,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              tgt_done,
    input logic              tgt_busy,
    input logic [ADDR_W-1:0] loc_wa,
    input logic [3:0]        loc_lbe_n,
    input logic [31:0]       loc_wdata,
    input logic              loc_strobe,
    input logic              loc_wait
);
    logic [1:0]        lat_mode;
    logic [ADDR_W-1:0] lat_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_mode <= '0;
            lat_addr <= '0;
        end else if (tgt_start && !tgt_busy) begin
            lat_mode <= bus_mode;
            lat_addr <= tgt_addr;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_done |=> !tgt_done); // R6
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_strobe && loc_wait) |=> (loc_strobe && $stable(loc_lbe_n) && $stable(loc_wdata))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_busy |-> (!loc_strobe && !tgt_done)); // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_start && !tgt_busy) |=> tgt_busy); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        loc_strobe |-> (loc_wa == lat_addr)); // R10
    AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_strobe && lat_mode == 2'd2) |-> (loc_lbe_n[3:2] == 2'b11 && loc_wdata[31:8] == '0)); // R3
    AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_strobe && lat_mode == 2'd1) |-> (loc_lbe_n[2] && loc_wdata[31:16] == '0)); // R2
endmodule

bind lbw_adapter lbw_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_mode   (bus_mode),
    .tgt_start  (tgt_start),
    .tgt_addr   (tgt_addr),
    .tgt_done   (tgt_done),
    .tgt_busy   (tgt_busy),
    .loc_wa     (loc_wa),
    .loc_lbe_n  (loc_lbe_n),
    .loc_wdata  (loc_wdata),
    .loc_strobe (loc_strobe),
    .loc_wait   (loc_wait)
);

// File: tb/tb_lbw_adapter.sv
module tb_lbw_adapter;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_mode = '0;
    logic          tgt_start = 1'b0;
    logic          tgt_write = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [3:0]    tgt_be_n = '1;
    logic [31:0]   tgt_wdata = '0;
    logic [31:0]   tgt_rdata;
    logic          tgt_done, tgt_busy;
    logic [AW-1:0] loc_wa;
    logic [3:0]    loc_lbe_n;
    logic [31:0]   loc_wdata, loc_rdata;
    logic          loc_strobe, loc_write;
    logic          loc_wait = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lbw_adapter #(.ADDR_W(AW)) dut (.*);

    // Local device: lane value depends on word address, lane and lane enables.
    function automatic logic [7:0] lval(logic [AW-1:0] wa, logic [3:0] lbe, int lane);
        return 8'(wa * 4 + lane) ^ {lbe, 4'h5};
    endfunction

    assign loc_rdata = {lval(loc_wa, loc_lbe_n, 3), lval(loc_wa, loc_lbe_n, 2),
                        lval(loc_wa, loc_lbe_n, 1), lval(loc_wa, loc_lbe_n, 0)};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_access(input int mode, input bit wr, input logic [AW-1:0] addr,
                              input logic [3:0] ben, input logic [31:0] wd,
                              input int waits, input bit poke);
        logic [3:0]  elbe [4];
        logic [31:0] ewd  [4];
        logic [31:0] erd;
        int n, idx, wl, gd;
        erd = '0;
        n = 0;
        for (int k = 0; k < 4; k++) begin elbe[k] = '1; ewd[k] = '0; end
        if (mode == 1) begin
            for (int h = 0; h < 2; h++) begin
                if (!ben[2*h] || !ben[2*h+1]) begin
                    elbe[n] = {ben[2*h+1], 1'b1, h[0], ben[2*h]};
                    for (int j = 2*h; j < 2*h+2; j++) begin
                        if (!ben[j]) begin
                            ewd[n][8*(j-2*h) +: 8] = wd[8*j +: 8];
                            erd[8*j +: 8] = lval(addr, elbe[n], j-2*h);
                        end
                    end
                    n++;
                end
            end
        end else if (mode == 2) begin
            for (int j = 0; j < 4; j++) begin
                if (!ben[j]) begin
                    elbe[n] = {2'b11, 2'(j)};
                    ewd[n][7:0] = wd[8*j +: 8];
                    erd[8*j +: 8] = lval(addr, elbe[n], 0);
                    n++;
                end
            end
        end else if (ben != 4'hF) begin
            elbe[0] = ben;
            for (int j = 0; j < 4; j++) begin
                if (!ben[j]) begin
                    ewd[0][8*j +: 8] = wd[8*j +: 8];
                    erd[8*j +: 8] = lval(addr, ben, j);
                end
            end
            n = 1;
        end

        @(negedge clk);
        bus_mode = 2'(mode); tgt_write = wr; tgt_addr = addr;
        tgt_be_n = ben; tgt_wdata = wd; tgt_start = 1'b1;
        @(negedge clk);
        tgt_start = 1'b0;
        // R8: scramble the inputs once the access is captured
        bus_mode = 2'((mode + 1) % 3); tgt_be_n = ~ben; tgt_wdata = ~wd; tgt_write = ~wr;
        chk(tgt_busy, "R7 busy after start", 32'(tgt_busy), 1);
        idx = 0; wl = waits; gd = 0;
        while (idx < n && gd < 100) begin
            gd++;
            chk(loc_strobe, "R5 strobe during unit", 32'(loc_strobe), 1);
            chk(loc_lbe_n == elbe[idx], mode == 2 ? "R3 lane enables" : (mode == 1 ? "R2 lane enables" : "R1 lane enables"),
                32'(loc_lbe_n), 32'(elbe[idx]));
            chk(loc_wa == addr, "R10 word address", 32'(loc_wa), 32'(addr));
            chk(loc_write == wr, "R8 direction held", 32'(loc_write), 32'(wr));
            if (wr) chk(loc_wdata == ewd[idx], "R10 write lanes", loc_wdata, ewd[idx]);
            if (poke && idx == 0 && wl == waits) tgt_start = 1'b1;
            if (wl > 0) begin
                loc_wait = 1'b1; wl--;
            end else begin
                loc_wait = 1'b0; idx++; wl = waits;
            end
            @(negedge clk);
            tgt_start = 1'b0;
        end
        loc_wait = 1'b0;
        chk(tgt_done && !loc_strobe, "R6 done after last unit", {tgt_done, loc_strobe}, 32'b10);
        if (!wr) chk(tgt_rdata == erd, "R4 read assembly", tgt_rdata, erd);
        @(negedge clk);
        chk(!tgt_done && !tgt_busy && !loc_strobe, "R7 idle after done", {tgt_done, tgt_busy, loc_strobe}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tgt_busy && !tgt_done && !loc_strobe && tgt_rdata == 0, "R9 reset state",
            {tgt_busy, tgt_done, loc_strobe, tgt_rdata[28:0]}, 0);
        for (int m = 0; m < 3; m++) begin
            for (int b = 0; b < 16; b++) begin
                for (int w = 0; w < 2; w++) begin
                    run_access(m, w[0], AW'(m*37 + b*5 + w), 4'(b),
                               32'hC3A5_5A3C ^ {4'(b), 4'(m), 24'h1F2E3D},
                               (b + m + w) % 3, b == 5);
                end
            end
        end
        // R1: reserved code behaves as 32-bit
        run_access(3, 1'b0, 8'h9C, 4'b0100, 32'h0, 1, 1'b0);
        run_access(3, 1'b1, 8'h9D, 4'b1010, 32'h1234_5678, 0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule